// File: doc/BRIEF.md
# Watchdog Timer Event Controller

This block watches for software or hardware hangs using a free-running time base. A 64-bit counter advances on every clock. A 2-bit period field picks one of four counter bits, and each 0-to-1 transition of that bit is a time-out. Time-outs cannot be turned off. Software can only steer what a time-out does, through a two-bit status machine made of an enable-next bit and an interrupt-status bit.

When enable-next is clear, a time-out only arms the machine. When the machine is armed, a time-out raises the interrupt status, which reaches the interrupt request line if both enables allow it. When the interrupt status is still set at the next time-out, the handler has evidently failed, and the block requests a reset. The reset scope comes from a two-bit control field whose bits software can set but never clear.

Software reaches the control and status fields through a small word-wide register port with a combinational read. The time base is readable in two words through the same port.

Top module: `wdt_event_ctrl`

## Requirements
- R1: After reset the time base is 0. It advances by one on every clock. Address 3 reads bits 31:0 and address 2 reads bits 63:32.
- R2: Control bits 1:0 hold the period code p. A time-out happens when time-base bit BASE_BIT+4p rises, so it recurs every 2^(BASE_BIT+1+4p) clocks. The default BASE_BIT of 16 gives 2^17, 2^21, 2^25 and 2^29. `tmo_o` is high for the one cycle after the counter edge where the bit rises.
- R3: A time-out while enable-next (status bit 0) is 0 sets enable-next. It leaves interrupt-status (status bit 1) unchanged and raises no reset.
- R4: A time-out while enable-next is 1 and interrupt-status is 0 sets interrupt-status.
- R5: A time-out while both status bits are 1 requests the reset selected by control bits 5:4 and copies that code into status bits 5:4. This happens whatever the interrupt enables are. The code 00 requests nothing and leaves status bits 5:4 unchanged.
- R6: Control bits 5:4 are set-only. A write ORs the written bits in, and only reset clears them.
- R7: `irq_o` is high exactly when control bit 2 (interrupt enable), `crit_en_i` and interrupt-status are all 1.
- R8: Writing address 1 clears each status bit among 1:0 written as 1. Writing address 2 with bit 0 set sets enable-next.
- R9: A status write (address 1 or 2) landing on the same clock edge as a time-out is discarded, and the time-out update is applied.
- R10: Reset code 01 pulses `rst_core_o`, 10 pulses `rst_chip_o` and 11 pulses `rst_sys_o`. Each pulse is one cycle long, starts with the matching `tmo_o` cycle, and at most one of the three is high at a time.
- R11: After reset the control and status registers read 0, and `irq_o`, `tmo_o` and all reset outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_en_i | input | 1 | Critical-interrupt enable from the core |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 enable-set and time-base high, 3 time-base low |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational on address |
| tmo_o | output | 1 | One-cycle time-out indication |
| irq_o | output | 1 | Watchdog interrupt request |
| rst_core_o | output | 1 | Core-only reset request pulse |
| rst_chip_o | output | 1 | Chip reset request pulse |
| rst_sys_o | output | 1 | System reset request pulse |

## Verification
A corrupted status state shows up by the very next time-out as a reset pulse that arrives one period early or late, or carries the wrong scope. It also shows immediately on `irq_o` and on a status read. A miscounted time base or wrong period decode moves `tmo_o` off the cycle that the bench computes from its own cycle count, so it is caught at the first expected time-out of each period code. A lost sticky bit or a mishandled same-edge status write is visible on the control or status read one cycle after the write lands.

// File: rtl/wdt_event_ctrl.sv
module wdt_event_ctrl #(
  parameter int TB_W     = 64,
  parameter int DW       = 32,
  parameter int BASE_BIT = 16,
  parameter int STEP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crit_en_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          tmo_o,
  output logic          irq_o,
  output logic          rst_core_o,
  output logic          rst_chip_o,
  output logic          rst_sys_o
);

  localparam int NPER = 4;

  logic [TB_W-1:0] tb_q;
  logic [1:0]      per_q, rc_q, last_q;
  logic            ie_q, enw_q, wis_q, tmo_q;
  logic            core_q, chip_q, sys_q;
  logic [NPER-1:0] hit;
  logic            fire, wr_ctrl, wr_stat, wr_set, bite;
  logic            unused_wdata;

  for (genvar g = 0; g < NPER; g++) begin : g_tap
    localparam int K = BASE_BIT + g * STEP;
    assign hit[g] = (tb_q[K:0] == {1'b0, {K{1'b1}}});
  end

  assign fire    = hit[per_q];
  assign bite    = fire && enw_q && wis_q;
  assign wr_ctrl = reg_we_i && (reg_addr_i == 2'd0);
  assign wr_stat = reg_we_i && (reg_addr_i == 2'd1);
  assign wr_set  = reg_we_i && (reg_addr_i == 2'd2);
  assign unused_wdata = ^{reg_wdata_i[DW-1:6], reg_wdata_i[3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_q   <= '0;
      per_q  <= '0;
      ie_q   <= 1'b0;
      rc_q   <= '0;
      enw_q  <= 1'b0;
      wis_q  <= 1'b0;
      last_q <= '0;
      tmo_q  <= 1'b0;
      core_q <= 1'b0;
      chip_q <= 1'b0;
      sys_q  <= 1'b0;
    end else begin
      tb_q   <= tb_q + 1'b1;
      tmo_q  <= fire;
      core_q <= bite && (rc_q == 2'b01);
      chip_q <= bite && (rc_q == 2'b10);
      sys_q  <= bite && (rc_q == 2'b11);
      if (wr_ctrl) begin
        per_q <= reg_wdata_i[1:0];
        ie_q  <= reg_wdata_i[2];
        rc_q  <= rc_q | reg_wdata_i[5:4];
      end
      if (fire) begin
        if (!enw_q)              enw_q  <= 1'b1;
        else if (!wis_q)         wis_q  <= 1'b1;
        else if (rc_q != 2'b00)  last_q <= rc_q;
      end else begin
        if (wr_stat && reg_wdata_i[0]) enw_q <= 1'b0;
        if (wr_stat && reg_wdata_i[1]) wis_q <= 1'b0;
        if (wr_set && reg_wdata_i[0])  enw_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      2'd0: reg_rdata_o[5:0] = {rc_q, 1'b0, ie_q, per_q};
      2'd1: reg_rdata_o[5:0] = {last_q, 2'b00, wis_q, enw_q};
      2'd2: reg_rdata_o = tb_q[TB_W-1 -: DW];
      default: reg_rdata_o = tb_q[DW-1:0];
    endcase
  end

  assign tmo_o      = tmo_q;
  assign irq_o      = ie_q && crit_en_i && wis_q;
  assign rst_core_o = core_q;
  assign rst_chip_o = chip_q;
  assign rst_sys_o  = sys_q;

  // R10
  reset_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_core_o, rst_chip_o, rst_sys_o}));

  // R10
  reset_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core_o || rst_chip_o || rst_sys_o) |=> !(rst_core_o || rst_chip_o || rst_sys_o));

  // R5
  reset_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_core_o || rst_chip_o || rst_sys_o) |-> ($past(enw_q) && $past(wis_q) && tmo_o));

  // R3
  disarmed_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enw_q |=> !(rst_core_o || rst_chip_o || rst_sys_o));

  // R4
  wis_rise_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wis_q) |-> ($past(enw_q) && tmo_o));

  // R6
  rc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_q != 2'b00) |=> ((rc_q & $past(rc_q)) == $past(rc_q)));

  // R2
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> !tmo_o);

endmodule

// File: tb/wdt_event_ctrl_tb_top.sv
module wdt_event_ctrl_tb_top;
  localparam int BB = 2;
  localparam int SP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crit_en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tmo_o, irq_o, rst_core_o, rst_chip_o, rst_sys_o;

  int          n_tests = 0;
  int          n_fail = 0;
  longint      cyc = 0;
  int          bwp = 0;
  logic [2:0]  exp_q[$];
  logic [31:0] rv;

  wdt_event_ctrl #(.TB_W(64), .DW(32), .BASE_BIT(BB), .STEP(SP)) dut_i (
    .clk(clk), .rst_n(rst_n), .crit_en_i(crit_en_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .tmo_o(tmo_o), .irq_o(irq_o), .rst_core_o(rst_core_o),
    .rst_chip_o(rst_chip_o), .rst_sys_o(rst_sys_o));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic to_cyc(input longint n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; crit_en_i = 1'b0; bwp = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: time-out timing and popped reset expectations
  always @(negedge clk) begin
    if (rst_n) begin
      longint half;
      logic   exp_t;
      logic [2:0] got, e;
      half  = longint'(1) << (BB + SP * bwp);
      exp_t = (cyc % (2 * half)) == half;
      got   = {rst_core_o, rst_chip_o, rst_sys_o};
      if (exp_t || tmo_o) check(tmo_o == exp_t, "R2 tmo timing", tmo_o, exp_t);
      if (tmo_o) begin
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 3'b000;
        check(got == e, "R5/R10 reset pulse", got, e);
      end else if (got != 3'b000) begin
        check(1'b0, "R10 pulse outside time-out", got, 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11 and R1: reset state and time base
    do_reset();
    rd(2'd0, rv); check(rv == 0, "R11 control", rv, 0);
    rd(2'd1, rv); check(rv == 0, "R11 status", rv, 0);
    check({irq_o, tmo_o, rst_core_o, rst_chip_o, rst_sys_o} == 0, "R11 outputs",
          {irq_o, tmo_o, rst_core_o, rst_chip_o, rst_sys_o}, 0);
    to_cyc(3);
    rd(2'd3, rv); check(rv == 3, "R1 time base low", rv, 3);
    rd(2'd2, rv); check(rv == 0, "R1 time base high", rv, 0);

    // R3 R4 R5 R7 R10: core reset sequence, period 8
    do_reset();
    exp_q.push_back(3'b000); exp_q.push_back(3'b000);
    exp_q.push_back(3'b100); exp_q.push_back(3'b100);
    crit_en_i = 1'b1;
    wr(2'd0, 32'h14);
    to_cyc(8);
    rd(2'd1, rv); check(rv == 32'h1, "R3 arm", rv, 1);
    check(irq_o == 0, "R3 no irq", irq_o, 0);
    to_cyc(14);
    rd(2'd1, rv); check(rv == 32'h3, "R4 status", rv, 3);
    check(irq_o == 1, "R7 irq on", irq_o, 1);
    to_cyc(22);
    rd(2'd1, rv); check(rv == 32'h13, "R5 last reset core", rv, 32'h13);
    to_cyc(30);
    check(exp_q.size() == 0, "R5 pulses consumed", exp_q.size(), 0);

    // R7 R8 R5(code 00)
    do_reset();
    repeat (5) exp_q.push_back(3'b000);
    crit_en_i = 1'b1;
    wr(2'd0, 32'h04);
    to_cyc(14);
    check(irq_o == 1, "R7 irq set", irq_o, 1);
    crit_en_i = 1'b0; #1;
    check(irq_o == 0, "R7 crit gate", irq_o, 0);
    crit_en_i = 1'b1;
    wr(2'd0, 32'h00);
    check(irq_o == 0, "R7 enable gate", irq_o, 0);
    wr(2'd0, 32'h04);
    to_cyc(22);
    rd(2'd1, rv); check(rv == 32'h3, "R5 code 00 no record", rv, 3);
    to_cyc(24);
    wr(2'd1, 32'h2);
    rd(2'd1, rv); check(rv == 32'h1, "R8 clear wis", rv, 1);
    check(irq_o == 0, "R8 irq drops", irq_o, 0);
    to_cyc(29);
    rd(2'd1, rv); check(rv == 32'h3, "R4 wis again", rv, 3);
    wr(2'd1, 32'h3);
    rd(2'd1, rv); check(rv == 32'h0, "R8 clear both", rv, 0);
    wr(2'd2, 32'h1);
    rd(2'd1, rv); check(rv == 32'h1, "R8 set enw", rv, 1);
    to_cyc(37);
    rd(2'd1, rv); check(rv == 32'h3, "R4 after set", rv, 3);
    to_cyc(40);
    check(exp_q.size() == 0, "R5 code 00 pulses", exp_q.size(), 0);

    // R6 R10: sticky scope, chip then system, irq disabled
    do_reset();
    exp_q.push_back(3'b000); exp_q.push_back(3'b000);
    exp_q.push_back(3'b010); exp_q.push_back(3'b001);
    wr(2'd0, 32'h24);
    rd(2'd0, rv); check(rv == 32'h24, "R6 set chip", rv, 32'h24);
    to_cyc(21);
    wr(2'd0, 32'h14);
    rd(2'd0, rv); check(rv == 32'h34, "R6 accumulate", rv, 32'h34);
    wr(2'd0, 32'h00);
    rd(2'd0, rv); check(rv == 32'h30, "R6 no clear", rv, 32'h30);
    to_cyc(29);
    rd(2'd1, rv); check(rv == 32'h33, "R10 last system", rv, 32'h33);
    to_cyc(31);
    check(exp_q.size() == 0, "R10 pulses consumed", exp_q.size(), 0);

    // R9: same-edge status writes lose to time-outs
    do_reset();
    exp_q.push_back(3'b000); exp_q.push_back(3'b000);
    crit_en_i = 1'b1;
    wr(2'd0, 32'h04);
    to_cyc(3);
    wr(2'd1, 32'h3);
    rd(2'd1, rv); check(rv == 32'h1, "R9 clear vs arm", rv, 1);
    to_cyc(11);
    wr(2'd1, 32'h2);
    rd(2'd1, rv); check(rv == 32'h3, "R9 clear vs wis", rv, 3);
    wr(2'd1, 32'h3);
    rd(2'd1, rv); check(rv == 32'h0, "R8 clear after", rv, 0);
    check(irq_o == 0, "R7 irq off", irq_o, 0);
    to_cyc(16);
    check(exp_q.size() == 0, "R9 pulses consumed", exp_q.size(), 0);

    // R2: other period codes (monitor checks timing)
    do_reset();
    bwp = 1; wr(2'd0, 32'h1);
    to_cyc(100);
    rd(2'd3, rv); check(rv == 100, "R1 count", rv, 100);
    to_cyc(200);
    do_reset();
    bwp = 2; wr(2'd0, 32'h2);
    to_cyc(3100);
    do_reset();
    bwp = 3; wr(2'd0, 32'h3);
    to_cyc(16390);
    rd(2'd1, rv); check(rv == 32'h1, "R2 longest period armed", rv, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule